// File: doc/BRIEF.md
# Two-Counter Event Performance Monitor

This block counts hardware events in two 32-bit counters, each steered by its own selector register. A selector holds an event code, a qualifier mask, two privilege-mode qualifiers, an overflow interrupt enable and a run bit. Events arrive on a set of lanes. Each lane presents an 8-bit event code, an 8-bit qualifier field and an increment of 0 to 3 per cycle. A counter adds, in one cycle, the increments of every lane whose code and qualifier match its selector.

Software reaches the four registers and an overflow status word through a simple register port. Writes use a strobe. Reads are registered with one cycle of latency. A single run bit, held in selector 0, starts and stops both counters together. Some event codes may count on only one of the two counters. One code and qualifier pairing counts nothing, so software can park a counter while the shared run bit stays set. Counters read back as 40 bits, with the top byte copying bit 31. A wrap past all-ones sets a sticky overflow flag. The interrupt request stays high until software clears that flag.

Top module: `pmon2_unit`

## Requirements
- R1: After a synchronous reset, all selectors, counters and overflow flags are zero, `irq` is low and `reg_rdata` is zero.
- R2: Register addresses are: 0 for selector 0, 1 for selector 1, 2 for counter 0, 3 for counter 1, and 4 for overflow status (bit i is counter i; writing 1 to bit i clears it). Addresses 5 to 7 read as zero. A selector reads back its full 32-bit value with zero in bits 39:32. A write strobed at one clock edge is visible from the next edge. `reg_rdata` shows the register addressed at the previous edge.
- R3: A counter write keeps `reg_wdata[31:0]`. A counter read returns the 32-bit value in bits 31:0, with bits 39:32 all equal to bit 31. For example, 0x80000001 reads as 0xFF80000001.
- R4: Bit 22 of selector 0 is the shared run bit. When it is clear, neither counter changes except by a write. Bit 22 of selector 1 has no effect.
- R5: Selector bits 7:0 are the event code and bits 15:8 are the qualifier mask. A counter adds the increments of all lanes whose code equals its event code, provided the lane's qualifier is zero or shares at least one set bit with the mask.
- R6: Selector bit 16 allows counting while `cpu_kmode` is 0 (user mode). Bit 17 allows counting while `cpu_kmode` is 1 (kernel mode).
- R7: Event code 0x2E with a zero qualifier mask never counts, even when a lane with code 0x2E and a zero qualifier is active.
- R8: Codes 0xC1, 0x10, 0x11 and 0x14 count only on counter 0. Codes 0x12 and 0x13 count only on counter 1. On the other counter they leave the value unchanged.
- R9: An increment that carries the counter past 0xFFFFFFFF sets that counter's sticky overflow flag. `irq` is high from the edge after any flag is set while the same selector's bit 20 is set. It stays high until that flag is cleared or bit 20 is cleared. If a set and a clear of a flag fall on the same edge, the set wins.
- R10: A counter write on the same edge as an increment stores the written value. Counting resumes on later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 40 | Registered read data |
| ev_code | input | NUM_EV*8 | Event code of each lane; lane i at [i*8 +: 8] |
| ev_qual | input | NUM_EV*8 | Qualifier bits of each lane |
| ev_inc | input | NUM_EV*2 | Increment (0..3) of each lane this cycle |
| cpu_kmode | input | 1 | 1 when the core runs in kernel mode |
| irq | output | 1 | Registered overflow interrupt request |

## Verification
The checks assume that the register port and event inputs change only between clock edges and are steady at each rising edge. They also assume that a counter write and an increment on the same edge are allowed, with the write winning. The hold-still properties are conditioned on there being no write to that counter in the same cycle, because the only other way a counter value changes is the gated increment. The stimulus drives every input at the falling edge. It leaves all lane increments at zero during register reads and selector writes, so each expected count depends only on the cycles in which the bench opens a lane window.

// File: rtl/pmon2_pkg.sv
package pmon2_pkg;

  localparam int CNT_W  = 32;
  localparam int RD_W   = 40;
  localparam int CODE_W = 8;

  localparam logic [2:0] ADR_SEL0 = 3'd0;
  localparam logic [2:0] ADR_SEL1 = 3'd1;
  localparam logic [2:0] ADR_CNT0 = 3'd2;
  localparam logic [2:0] ADR_CNT1 = 3'd3;
  localparam logic [2:0] ADR_STAT = 3'd4;

  // Selector word: code 7:0, mask 15:8, user 16, kernel 17, int-enable 20, run 22
  typedef struct packed {
    logic [8:0] rsv_hi;
    logic       run;
    logic       rsv21;
    logic       ie;
    logic [1:0] rsv18;
    logic       krn;
    logic       usr;
    logic [7:0] mask;
    logic [7:0] code;
  } sel_t;

  localparam logic [7:0] PARK_CODE = 8'h2E;

  function automatic logic code_allowed(input logic [7:0] code, input int unsigned idx);
    logic ok;
    unique case (code)
      8'hC1, 8'h10, 8'h11, 8'h14: ok = (idx == 0);
      8'h12, 8'h13:               ok = (idx == 1);
      default:                    ok = 1'b1;
    endcase
    return ok;
  endfunction

  function automatic logic is_parked(input sel_t s);
    return (s.code == PARK_CODE) && (s.mask == 8'h00);
  endfunction

endpackage

// File: rtl/pmon2_lane_sum.sv
module pmon2_lane_sum #(
  parameter int NUM_EV = 4,
  parameter int INC_W  = 2,
  parameter int SUM_W  = 4
) (
  input  logic [7:0]              sel_code,
  input  logic [7:0]              sel_mask,
  input  logic [NUM_EV*8-1:0]     ev_code,
  input  logic [NUM_EV*8-1:0]     ev_qual,
  input  logic [NUM_EV*INC_W-1:0] ev_inc,
  output logic [SUM_W-1:0]        sum
);

  logic [NUM_EV-1:0][SUM_W-1:0] lane_val;

  for (genvar g = 0; g < NUM_EV; g++) begin : g_lane
    logic code_hit;
    logic qual_hit;
    assign code_hit = (ev_code[g*8 +: 8] == sel_code);
    assign qual_hit = (ev_qual[g*8 +: 8] == 8'h00) ||
                      ((ev_qual[g*8 +: 8] & sel_mask) != 8'h00);
    assign lane_val[g] = (code_hit && qual_hit) ?
                         SUM_W'(ev_inc[g*INC_W +: INC_W]) : '0;
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < NUM_EV; i++) begin
      sum = sum + lane_val[i];
    end
  end

endmodule

// File: rtl/pmon2_ctr.sv
module pmon2_ctr
  import pmon2_pkg::*;
#(
  parameter int          CW    = 32,
  parameter int          SUM_W = 4,
  parameter int unsigned IDX   = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  sel_t             sel,
  input  logic             glb_run,
  input  logic             kmode,
  input  logic [SUM_W-1:0] inc_sum,
  input  logic             wr,
  input  logic [CW-1:0]    wdata,
  input  logic             clr,
  output logic [CW-1:0]    cnt_q,
  output logic             ovf_q
);

  logic          priv_ok;
  logic          qual;
  logic [CW:0]   nxt;
  logic          unused_sel;

  assign unused_sel = ^{sel.rsv_hi, sel.run, sel.rsv21, sel.ie, sel.rsv18};
  assign priv_ok = kmode ? sel.krn : sel.usr;
  assign qual    = glb_run && priv_ok && code_allowed(sel.code, IDX) && !is_parked(sel);
  assign nxt     = {1'b0, cnt_q} + (qual ? (CW+1)'(inc_sum) : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (wr) cnt_q <= wdata;
      else    cnt_q <= nxt[CW-1:0];
      if (!wr && nxt[CW]) ovf_q <= 1'b1;
      else if (clr)       ovf_q <= 1'b0;
    end
  end

endmodule

// File: rtl/pmon2_unit.sv
module pmon2_unit
  import pmon2_pkg::*;
#(
  parameter int NUM_EV = 4,
  parameter int INC_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_wr,
  input  logic [2:0]              reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [RD_W-1:0]         reg_rdata,
  input  logic [NUM_EV*8-1:0]     ev_code,
  input  logic [NUM_EV*8-1:0]     ev_qual,
  input  logic [NUM_EV*INC_W-1:0] ev_inc,
  input  logic                    cpu_kmode,
  output logic                    irq
);

  localparam int NUM_CTR = 2;
  localparam int EXT_W   = RD_W - CNT_W;
  localparam int MAX_SUM = NUM_EV * ((1 << INC_W) - 1);
  localparam int SUM_W   = $clog2(MAX_SUM + 1);

  sel_t [NUM_CTR-1:0]            sel_q;
  logic [NUM_CTR-1:0][CNT_W-1:0] cnt_q;
  logic [NUM_CTR-1:0]            ovf_q;
  logic [NUM_CTR-1:0]            ie_vec;
  logic [RD_W-1:0]               rd_nxt;

  for (genvar c = 0; c < NUM_CTR; c++) begin : g_ctr
    logic [SUM_W-1:0] inc_sum;
    logic             sel_we;
    logic             cnt_we;

    assign sel_we    = reg_wr && (reg_addr == ADR_SEL0 + 3'(c));
    assign cnt_we    = reg_wr && (reg_addr == ADR_CNT0 + 3'(c));
    assign ie_vec[c] = sel_q[c].ie;

    always_ff @(posedge clk) begin
      if (rst)         sel_q[c] <= '0;
      else if (sel_we) sel_q[c] <= sel_t'(reg_wdata);
    end

    pmon2_lane_sum #(.NUM_EV(NUM_EV), .INC_W(INC_W), .SUM_W(SUM_W)) u_sum (
      .sel_code (sel_q[c].code),
      .sel_mask (sel_q[c].mask),
      .ev_code  (ev_code),
      .ev_qual  (ev_qual),
      .ev_inc   (ev_inc),
      .sum      (inc_sum)
    );

    pmon2_ctr #(.CW(CNT_W), .SUM_W(SUM_W), .IDX(c)) u_ctr (
      .clk     (clk),
      .rst     (rst),
      .sel     (sel_q[c]),
      .glb_run (sel_q[0].run),
      .kmode   (cpu_kmode),
      .inc_sum (inc_sum),
      .wr      (cnt_we),
      .wdata   (reg_wdata[CNT_W-1:0]),
      .clr     (reg_wr && (reg_addr == ADR_STAT) && reg_wdata[c]),
      .cnt_q   (cnt_q[c]),
      .ovf_q   (ovf_q[c])
    );
  end

  always_comb begin
    unique case (reg_addr)
      ADR_SEL0: rd_nxt = {{EXT_W{1'b0}}, sel_q[0]};
      ADR_SEL1: rd_nxt = {{EXT_W{1'b0}}, sel_q[1]};
      ADR_CNT0: rd_nxt = {{EXT_W{cnt_q[0][CNT_W-1]}}, cnt_q[0]};
      ADR_CNT1: rd_nxt = {{EXT_W{cnt_q[1][CNT_W-1]}}, cnt_q[1]};
      ADR_STAT: rd_nxt = {{(RD_W-NUM_CTR){1'b0}}, ovf_q};
      default:  rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      reg_rdata <= rd_nxt;
      irq       <= |(ovf_q & ie_vec);
    end
  end

endmodule

// File: rtl/pmon2_unit_chk.sv
module pmon2_unit_chk
  import pmon2_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [39:0]       reg_rdata,
  input sel_t [1:0]        sel,
  input logic [1:0][31:0]  cnt,
  input logic [1:0]        ovf,
  input logic              irq
);

  logic we0, we1, clr0;
  assign we0  = reg_wr && (reg_addr == ADR_CNT0);
  assign we1  = reg_wr && (reg_addr == ADR_CNT1);
  assign clr0 = reg_wr && (reg_addr == ADR_STAT) && reg_wdata[0];

  assert_upper_mirror_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == ADR_CNT0 || reg_addr == ADR_CNT1) |=> (reg_rdata[39:32] == {8{reg_rdata[31]}}));

  assert_run_off_c0_R4: assert property (@(posedge clk) disable iff (rst)
    (!sel[0].run && !we0) |=> $stable(cnt[0]));

  assert_run_off_c1_R4: assert property (@(posedge clk) disable iff (rst)
    (!sel[0].run && !we1) |=> $stable(cnt[1]));

  assert_park_c1_R7: assert property (@(posedge clk) disable iff (rst)
    (is_parked(sel[1]) && !we1) |=> $stable(cnt[1]));

  assert_forbid_c0_R8: assert property (@(posedge clk) disable iff (rst)
    (!code_allowed(sel[0].code, 0) && !we0) |=> $stable(cnt[0]));

  assert_forbid_c1_R8: assert property (@(posedge clk) disable iff (rst)
    (!code_allowed(sel[1].code, 1) && !we1) |=> $stable(cnt[1]));

  assert_irq_set_R9: assert property (@(posedge clk) disable iff (rst)
    (|(ovf & {sel[1].ie, sel[0].ie})) |=> irq);

  assert_irq_low_R9: assert property (@(posedge clk) disable iff (rst)
    !(|(ovf & {sel[1].ie, sel[0].ie})) |=> !irq);

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (ovf[0] && !clr0) |=> ovf[0]);

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
    we0 |=> (cnt[0] == $past(reg_wdata)));

endmodule

bind pmon2_unit pmon2_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .sel       (sel_q),
  .cnt       (cnt_q),
  .ovf       (ovf_q),
  .irq       (irq)
);

// File: tb/pmon2_unit_tb.sv
`timescale 1ns/1ps
module pmon2_unit_tb;

  localparam int NEV = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_wr = 1'b0;
  logic [2:0]        reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [39:0]       reg_rdata;
  logic [NEV*8-1:0]  ev_code;
  logic [NEV*8-1:0]  ev_qual;
  logic [NEV*2-1:0]  ev_inc;
  logic              cpu_kmode = 1'b0;
  logic              irq;

  logic [7:0] lcode [NEV];
  logic [7:0] lqual [NEV];
  logic [1:0] linc  [NEV];

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NEV; i++) begin
      ev_code[i*8 +: 8] = lcode[i];
      ev_qual[i*8 +: 8] = lqual[i];
      ev_inc[i*2 +: 2]  = linc[i];
    end
  end

  pmon2_unit #(.NUM_EV(NEV), .INC_W(2)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_code(ev_code),
    .ev_qual(ev_qual), .ev_inc(ev_inc), .cpu_kmode(cpu_kmode), .irq(irq)
  );

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lanes_off();
    for (int i = 0; i < NEV; i++) begin
      lcode[i] = 8'h00; lqual[i] = 8'h00; linc[i] = 2'd0;
    end
  endtask

  task automatic set_lane(input int i, input logic [7:0] c, input logic [7:0] q, input logic [1:0] n);
    lcode[i] = c; lqual[i] = q; linc[i] = n;
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [39:0] v);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    #1 v = reg_rdata;
  endtask

  // lanes are configured beforehand with zero increments; run_lanes applies inc for n edges
  task automatic run_lanes(input logic [1:0] inc [NEV], input int n);
    @(negedge clk);
    for (int i = 0; i < NEV; i++) linc[i] = inc[i];
    repeat (n) @(negedge clk);
    for (int i = 0; i < NEV; i++) linc[i] = 2'd0;
  endtask

  task automatic zero_counts();
    bus_wr(3'd2, 32'h0);
    bus_wr(3'd3, 32'h0);
  endtask

  task automatic t_reset();
    logic [39:0] v;
    for (int a = 0; a < 5; a++) begin
      bus_rd(3'(a), v);
      chk("R1 reset register", v, 40'h0);
    end
    chk("R1 reset irq", {39'h0, irq}, 40'h0);
  endtask

  task automatic t_regs();
    logic [39:0] v;
    bus_wr(3'd1, 32'hDEADBEEF);
    bus_rd(3'd1, v);
    chk("R2 selector readback", v, 40'h00DEADBEEF);
    bus_wr(3'd1, 32'h0);
    bus_wr(3'd3, 32'h12345678);
    bus_rd(3'd3, v);
    chk("R2 counter readback", v, 40'h0012345678);
    bus_rd(3'd7, v);
    chk("R2 unused address", v, 40'h0);
  endtask

  task automatic t_ext();
    logic [39:0] v;
    bus_wr(3'd2, 32'h80000001);
    bus_rd(3'd2, v);
    chk("R3 sign extend max period", v, 40'hFF80000001);
    bus_wr(3'd2, 32'h7FFFFFFF);
    bus_rd(3'd2, v);
    chk("R3 positive read", v, 40'h007FFFFFFF);
    bus_wr(3'd2, 32'hFFFFFFFF);
    bus_rd(3'd2, v);
    chk("R3 all ones", v, 40'hFFFFFFFFFF);
  endtask

  task automatic t_enable();
    logic [39:0] v;
    logic [1:0] inc [NEV];
    zero_counts();
    lanes_off();
    set_lane(0, 8'h79, 8'h00, 2'd0);
    set_lane(1, 8'hC0, 8'h00, 2'd0);
    inc = '{2'd1, 2'd2, 2'd0, 2'd0};
    bus_wr(3'd0, 32'h00030079);
    bus_wr(3'd1, 32'h004300C0);
    run_lanes(inc, 4);
    bus_rd(3'd2, v); chk("R4 run off counter0", v, 40'h0);
    bus_rd(3'd3, v); chk("R4 run bit in selector1 ignored", v, 40'h0);
    bus_wr(3'd0, 32'h00430079);
    bus_wr(3'd1, 32'h000300C0);
    run_lanes(inc, 4);
    bus_rd(3'd2, v); chk("R4 run on counter0", v, 40'd4);
    bus_rd(3'd3, v); chk("R4 run on counter1", v, 40'd8);
  endtask

  task automatic t_match();
    logic [39:0] v;
    logic [1:0] inc [NEV];
    zero_counts();
    lanes_off();
    set_lane(0, 8'h79, 8'h00, 2'd0);
    set_lane(1, 8'h79, 8'h00, 2'd0);
    set_lane(2, 8'h2E, 8'h01, 2'd0);
    set_lane(3, 8'h2E, 8'h10, 2'd0);
    inc = '{2'd1, 2'd3, 2'd1, 2'd2};
    bus_wr(3'd0, 32'h00430079);
    bus_wr(3'd1, 32'h00030F2E);
    run_lanes(inc, 5);
    bus_rd(3'd2, v); chk("R5 lanes summed", v, 40'd20);
    bus_rd(3'd3, v); chk("R5 qualifier mask", v, 40'd5);
    bus_wr(3'd1, 32'h00031F2E);
    run_lanes(inc, 2);
    bus_rd(3'd3, v); chk("R5 wider mask", v, 40'd11);
  endtask

  task automatic t_priv();
    logic [39:0] v;
    logic [1:0] inc [NEV];
    zero_counts();
    lanes_off();
    set_lane(0, 8'h79, 8'h00, 2'd0);
    set_lane(1, 8'hC0, 8'h00, 2'd0);
    inc = '{2'd1, 2'd1, 2'd0, 2'd0};
    bus_wr(3'd0, 32'h00410079);
    bus_wr(3'd1, 32'h000200C0);
    cpu_kmode = 1'b1;
    run_lanes(inc, 3);
    cpu_kmode = 1'b0;
    run_lanes(inc, 2);
    bus_rd(3'd2, v); chk("R6 user-only counter", v, 40'd2);
    bus_rd(3'd3, v); chk("R6 kernel-only counter", v, 40'd3);
  endtask

  task automatic t_park();
    logic [39:0] v;
    logic [1:0] inc [NEV];
    zero_counts();
    lanes_off();
    set_lane(0, 8'h2E, 8'h00, 2'd0);
    set_lane(1, 8'h2E, 8'h01, 2'd0);
    set_lane(2, 8'h79, 8'h00, 2'd0);
    inc = '{2'd3, 2'd2, 2'd1, 2'd0};
    bus_wr(3'd0, 32'h00430079);
    bus_wr(3'd1, 32'h0003002E);
    run_lanes(inc, 4);
    bus_rd(3'd3, v); chk("R7 parked counter", v, 40'd0);
    bus_rd(3'd2, v); chk("R7 other counter still runs", v, 40'd4);
  endtask

  task automatic t_constraint();
    logic [39:0] v;
    logic [1:0] inc [NEV];
    zero_counts();
    lanes_off();
    set_lane(0, 8'h12, 8'h00, 2'd0);
    inc = '{2'd1, 2'd0, 2'd0, 2'd0};
    bus_wr(3'd0, 32'h00430012);
    bus_wr(3'd1, 32'h00030012);
    run_lanes(inc, 3);
    bus_rd(3'd2, v); chk("R8 code 0x12 barred on counter0", v, 40'd0);
    bus_rd(3'd3, v); chk("R8 code 0x12 on counter1", v, 40'd3);
    zero_counts();
    set_lane(0, 8'hC1, 8'h00, 2'd0);
    inc = '{2'd2, 2'd0, 2'd0, 2'd0};
    bus_wr(3'd0, 32'h004300C1);
    bus_wr(3'd1, 32'h000300C1);
    run_lanes(inc, 3);
    bus_rd(3'd2, v); chk("R8 code 0xC1 on counter0", v, 40'd6);
    bus_rd(3'd3, v); chk("R8 code 0xC1 barred on counter1", v, 40'd0);
  endtask

  task automatic t_overflow();
    logic [39:0] v;
    logic [1:0] inc [NEV];
    lanes_off();
    set_lane(0, 8'h79, 8'h00, 2'd0);
    set_lane(1, 8'hC0, 8'h00, 2'd0);
    inc = '{2'd1, 2'd1, 2'd0, 2'd0};
    bus_wr(3'd0, 32'h00530079);
    bus_wr(3'd1, 32'h000300C0);
    bus_wr(3'd2, 32'hFFFFFFFE);
    bus_wr(3'd3, 32'hFFFFFFFF);
    chk("R9 irq low before wrap", {39'h0, irq}, 40'h0);
    run_lanes(inc, 3);
    bus_rd(3'd4, v); chk("R9 both overflow flags", v, 40'h3);
    chk("R9 irq raised", {39'h0, irq}, 40'h1);
    bus_rd(3'd2, v); chk("R9 wrapped counter0", v, 40'd1);
    bus_wr(3'd4, 32'h1);
    bus_rd(3'd4, v); chk("R9 flag0 cleared", v, 40'h2);
    chk("R9 irq low without enable", {39'h0, irq}, 40'h0);
    bus_wr(3'd4, 32'h2);
    bus_rd(3'd4, v); chk("R9 flags clear", v, 40'h0);
  endtask

  task automatic t_write();
    logic [39:0] v;
    logic [1:0] inc [NEV];
    lanes_off();
    set_lane(0, 8'h79, 8'h00, 2'd0);
    bus_wr(3'd0, 32'h00430079);
    bus_wr(3'd2, 32'd5);
    @(negedge clk);
    linc[0] = 2'd1; reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'd100;
    @(negedge clk);
    linc[0] = 2'd0; reg_wr = 1'b0;
    bus_rd(3'd2, v); chk("R10 write beats increment", v, 40'd100);
    inc = '{2'd1, 2'd0, 2'd0, 2'd0};
    run_lanes(inc, 2);
    bus_rd(3'd2, v); chk("R10 counting resumes", v, 40'd102);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    lanes_off();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_ext();
    t_enable();
    t_match();
    t_priv();
    t_park();
    t_constraint();
    t_overflow();
    t_write();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule